// File: doc/BRIEF.md
# Shared-Region Bus Request Sequencer

This sequencer sits in a processor's bus interface and decides how each access request proceeds. An address range of the memory map (region number 2 by default) can be lent to an external bus master. Accesses to every other region start at once. Once sharing mode is on, an access to the shared region first pulls an active-low request line toward the external master. It then waits for a stable grant, launches the access, and gives the bus back when the access ends.

When the shared device is synchronous DRAM, the request line stays asserted for a fixed auto-precharge interval after the access ends. The requesting core gets a one-cycle completion pulse after the bus has been handed back. The sharing-enable and DRAM-type bits live in a small configuration register. A power-on reset clears that register, and a soft reset leaves it intact. The memory timing itself is outside this block: an access-end input reports when the cycle is finished.

Top module: `shreg_bus_seq`

## Requirements
- R1: A request is private when its region field differs from the shared region number or sharing mode is off. On the edge that accepts it, `accStart` rises for exactly one cycle and `busReqN` stays high throughout.
- R2: When sharing is on and a request targets the shared region, `busReqN` goes low on the accepting edge. `accStart` stays low for as long as `busGntN` is high.
- R3: The grant counts only when `busGntN` is sampled low at two consecutive rising edges while the request is held. A single low sample is discarded, and counting starts again from zero.
- R4: If `busGntN` is sampled low at edges a and a+1, `accStart` is high for exactly one cycle, beginning at edge a+2.
- R5: For a shared access with sharing configured as non-DRAM, `busReqN` stays low until `accEnd` is sampled high during the access. It returns high on that same edge.
- R6: When the DRAM bit is set, `busReqN` stays low for `PRECH_CYC` further cycles after the edge that samples `accEnd`. A `PRECH_CYC` of zero gives no extra cycles.
- R7: `accDone` is a one-cycle pulse that rises one edge after `busReqN` has returned high. For private accesses it rises on the edge that samples `accEnd`. New requests are ignored from acceptance until `accDone` has fallen.
- R8: While sharing is on, a request with `accIsRefresh` high that targets the shared region is dropped. It never lowers `busReqN` and never raises `accStart`, and `accDone` pulses on the next edge.
- R9: The region field is the top 3 bits of `accAddr` (bits 31:29 by default).
- R10: A power-on reset sets `busReqN` high and `accStart`/`accDone` low, and clears both configuration bits. `cfgWrEn` high at an edge loads `cfgShareEn` and `cfgSdram`.
- R11: A soft reset returns the sequencer to idle with `busReqN` high and retains the configuration bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all logic on the rising edge |
| porRstN | input | 1 | Power-on reset, active low, synchronous; clears configuration |
| softRstN | input | 1 | Soft reset, active low, synchronous; keeps configuration |
| cfgWrEn | input | 1 | Load the configuration bits |
| cfgShareEn | input | 1 | Sharing mode enable value |
| cfgSdram | input | 1 | Shared device is synchronous DRAM |
| accReq | input | 1 | Access request, sampled only while idle |
| accAddr | input | ADDR_W | Access address; top REGION_W bits select the region |
| accIsRefresh | input | 1 | The request is a refresh |
| accEnd | input | 1 | The running access has finished |
| busGntN | input | 1 | Grant from the external master, active low |
| busReqN | output | 1 | Bus request toward the external master, active low |
| accStart | output | 1 | One-cycle access launch strobe |
| accDone | output | 1 | One-cycle completion pulse to the core |

## Verification
A sequencer stuck in a waiting state shows up at once as `busReqN` held low with no `accStart` while the grant is present. A wrong count in the grant qualifier moves the `accStart` rising edge by one cycle, and this is visible within three edges of the grant. A faulty precharge counter shows up as `busReqN` releasing early or late against the exact cycle number after `accEnd`. A configuration register that is wrongly reset becomes visible on the next shared-region request, whose request line then behaves as private or shared in the wrong way.

// File: rtl/shreg_pkg.sv
package shreg_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_REQ,
    ST_GNTOK,
    ST_LAUNCH,
    ST_RUN,
    ST_PRECH,
    ST_REL,
    ST_PSTART,
    ST_PRUN,
    ST_DONE
  } seqState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic reqOn;     // request line low after this edge
    logic startOn;   // launch strobe after this edge
    logic doneOn;    // completion pulse after this edge
    logic trackGnt;  // sample grant at this edge
    logic loadWait;  // load precharge counter
    logic stepWait;  // count precharge down
  } seqStrb_t;

  // datapath -> control status
  typedef struct packed {
    logic sharedHit;
    logic refreshDrop;
    logic gntTwice;
    logic waitLast;
    logic sdramOn;
  } dpStat_t;

endpackage

// File: rtl/shreg_ctrl.sv
module shreg_ctrl
  import shreg_pkg::*;
#(
  parameter bit HAS_WAIT = 1'b1
) (
  input  logic     clk,
  input  logic     seqRstN,
  input  logic     accReq,
  input  logic     accEnd,
  input  dpStat_t  stat,
  output seqStrb_t strb
);

  seqState_t state, nxt;

  always_ff @(posedge clk) begin
    if (!seqRstN) state <= ST_IDLE;
    else          state <= nxt;
  end

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: begin
        if (accReq) begin
          if (stat.refreshDrop)    nxt = ST_DONE;
          else if (stat.sharedHit) nxt = ST_REQ;
          else                     nxt = ST_PSTART;
        end
      end
      ST_REQ:    if (stat.gntTwice) nxt = ST_GNTOK;
      ST_GNTOK:  nxt = ST_LAUNCH;
      ST_LAUNCH: nxt = ST_RUN;
      ST_RUN: begin
        if (accEnd) nxt = (stat.sdramOn && HAS_WAIT) ? ST_PRECH : ST_REL;
      end
      ST_PRECH:  if (stat.waitLast) nxt = ST_REL;
      ST_REL:    nxt = ST_DONE;
      ST_PSTART: nxt = ST_PRUN;
      ST_PRUN:   if (accEnd) nxt = ST_DONE;
      ST_DONE:   nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_comb begin
    strb.reqOn    = (nxt == ST_REQ) || (nxt == ST_GNTOK) || (nxt == ST_LAUNCH) ||
                    (nxt == ST_RUN) || (nxt == ST_PRECH);
    strb.startOn  = (nxt == ST_LAUNCH) || (nxt == ST_PSTART);
    strb.doneOn   = (nxt == ST_DONE);
    strb.trackGnt = (state == ST_REQ);
    strb.loadWait = (state == ST_RUN) && (nxt == ST_PRECH);
    strb.stepWait = (state == ST_PRECH);
  end

endmodule

// File: rtl/shreg_dp.sv
module shreg_dp
  import shreg_pkg::*;
#(
  parameter int unsigned ADDR_W        = 32,
  parameter int unsigned REGION_W      = 3,
  parameter int unsigned SHARED_REGION = 2,
  parameter int unsigned WAIT_W        = 4,
  parameter int unsigned PRECH_CYC     = 3
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              seqRstN,
  input  logic              cfgWrEn,
  input  logic              cfgShareEn,
  input  logic              cfgSdram,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              accIsRefresh,
  input  logic              busGntN,
  input  seqStrb_t          strb,
  output dpStat_t           stat,
  output logic              busReqN,
  output logic              accStart,
  output logic              accDone
);

  localparam logic [REGION_W-1:0] SHARED_ID = REGION_W'(SHARED_REGION);
  localparam logic [WAIT_W-1:0]   WAIT_LOAD = WAIT_W'(PRECH_CYC);

  logic                shareEnQ, sdramQ;
  logic                gntPrev;
  logic [WAIT_W-1:0]   waitCnt;
  logic [REGION_W-1:0] regionId;
  logic                unusedAddrBits;

  // configuration: cleared by power-on only
  always_ff @(posedge clk) begin
    if (!porRstN) begin
      shareEnQ <= 1'b0;
      sdramQ   <= 1'b0;
    end else if (cfgWrEn) begin
      shareEnQ <= cfgShareEn;
      sdramQ   <= cfgSdram;
    end
  end

  assign regionId       = accAddr[ADDR_W-1 -: REGION_W];
  assign unusedAddrBits = ^accAddr[ADDR_W-REGION_W-1:0];

  // grant history: one flop of consecutive low samples
  always_ff @(posedge clk) begin
    if (!seqRstN) gntPrev <= 1'b0;
    else          gntPrev <= strb.trackGnt && !busGntN;
  end

  // auto-precharge countdown
  always_ff @(posedge clk) begin
    if (!seqRstN)                           waitCnt <= '0;
    else if (strb.loadWait)                 waitCnt <= WAIT_LOAD;
    else if (strb.stepWait && waitCnt != 0) waitCnt <= waitCnt - 1'b1;
  end

  always_comb begin
    stat.sharedHit   = shareEnQ && (regionId == SHARED_ID);
    stat.refreshDrop = shareEnQ && (regionId == SHARED_ID) && accIsRefresh;
    stat.gntTwice    = strb.trackGnt && !busGntN && gntPrev;
    stat.waitLast    = (waitCnt == WAIT_W'(1));
    stat.sdramOn     = sdramQ;
  end

  // registered outputs
  always_ff @(posedge clk) begin
    if (!seqRstN) begin
      busReqN  <= 1'b1;
      accStart <= 1'b0;
      accDone  <= 1'b0;
    end else begin
      busReqN  <= !strb.reqOn;
      accStart <= strb.startOn;
      accDone  <= strb.doneOn;
    end
  end

endmodule

// File: rtl/shreg_bus_seq.sv
module shreg_bus_seq
  import shreg_pkg::*;
#(
  parameter int unsigned ADDR_W        = 32,
  parameter int unsigned REGION_W      = 3,
  parameter int unsigned SHARED_REGION = 2,
  parameter int unsigned WAIT_W        = 4,
  parameter int unsigned PRECH_CYC     = 3
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              softRstN,
  input  logic              cfgWrEn,
  input  logic              cfgShareEn,
  input  logic              cfgSdram,
  input  logic              accReq,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              accIsRefresh,
  input  logic              accEnd,
  input  logic              busGntN,
  output logic              busReqN,
  output logic              accStart,
  output logic              accDone
);

  localparam bit HAS_WAIT = (PRECH_CYC != 0);

  logic     seqRstN;
  seqStrb_t strb;
  dpStat_t  stat;

  assign seqRstN = porRstN && softRstN;

  shreg_ctrl #(.HAS_WAIT(HAS_WAIT)) u_ctrl (
    .clk     (clk),
    .seqRstN (seqRstN),
    .accReq  (accReq),
    .accEnd  (accEnd),
    .stat    (stat),
    .strb    (strb)
  );

  shreg_dp #(
    .ADDR_W        (ADDR_W),
    .REGION_W      (REGION_W),
    .SHARED_REGION (SHARED_REGION),
    .WAIT_W        (WAIT_W),
    .PRECH_CYC     (PRECH_CYC)
  ) u_dp (
    .clk          (clk),
    .porRstN      (porRstN),
    .seqRstN      (seqRstN),
    .cfgWrEn      (cfgWrEn),
    .cfgShareEn   (cfgShareEn),
    .cfgSdram     (cfgSdram),
    .accAddr      (accAddr),
    .accIsRefresh (accIsRefresh),
    .busGntN      (busGntN),
    .strb         (strb),
    .stat         (stat),
    .busReqN      (busReqN),
    .accStart     (accStart),
    .accDone      (accDone)
  );

endmodule

// File: rtl/shreg_bus_seq_chk.sv
module shreg_bus_seq_chk (
  input logic clk,
  input logic porRstN,
  input logic softRstN,
  input logic busGntN,
  input logic busReqN,
  input logic accStart,
  input logic accDone
);

  // R4: a shared launch follows two consecutive low grant samples
  p_launch_two_grants_r4: assert property (@(posedge clk)
    disable iff (!porRstN || !softRstN)
    (accStart && !busReqN) |-> (!$past(busGntN, 2) && !$past(busGntN, 3)));

  // R4: launch strobe lasts one cycle
  p_start_single_r4: assert property (@(posedge clk)
    disable iff (!porRstN || !softRstN)
    accStart |=> !accStart);

  // R7: completion pulse lasts one cycle
  p_done_single_r7: assert property (@(posedge clk)
    disable iff (!porRstN || !softRstN)
    accDone |=> !accDone);

  // R7: completion only once the bus is back
  p_done_after_release_r7: assert property (@(posedge clk)
    disable iff (!porRstN || !softRstN)
    accDone |-> (busReqN && $past(busReqN)));

  // R7: no launch while completing
  p_done_no_start_r7: assert property (@(posedge clk)
    disable iff (!porRstN || !softRstN)
    accDone |-> !accStart);

endmodule

bind shreg_bus_seq shreg_bus_seq_chk u_chk (
  .clk      (clk),
  .porRstN  (porRstN),
  .softRstN (softRstN),
  .busGntN  (busGntN),
  .busReqN  (busReqN),
  .accStart (accStart),
  .accDone  (accDone)
);

// File: tb/shreg_bus_seq_bench.sv
module shreg_bus_seq_bench;

  logic        clk = 1'b0;
  logic        porRstN = 1'b0;
  logic        softRstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic        cfgShareEn = 1'b0;
  logic        cfgSdram = 1'b0;
  logic        accReq = 1'b0;
  logic [31:0] accAddr = '0;
  logic        accIsRefresh = 1'b0;
  logic        accEnd = 1'b0;
  logic        busGntN = 1'b1;
  logic        busReqN, accStart, accDone;
  logic        zBusReqN, zAccStart, zAccDone;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  shreg_bus_seq u_shreg_bus_seq (
    .clk(clk), .porRstN(porRstN), .softRstN(softRstN),
    .cfgWrEn(cfgWrEn), .cfgShareEn(cfgShareEn), .cfgSdram(cfgSdram),
    .accReq(accReq), .accAddr(accAddr), .accIsRefresh(accIsRefresh),
    .accEnd(accEnd), .busGntN(busGntN),
    .busReqN(busReqN), .accStart(accStart), .accDone(accDone)
  );

  shreg_bus_seq #(.PRECH_CYC(0)) u_shreg_bus_seq_nowait (
    .clk(clk), .porRstN(porRstN), .softRstN(softRstN),
    .cfgWrEn(cfgWrEn), .cfgShareEn(cfgShareEn), .cfgSdram(cfgSdram),
    .accReq(accReq), .accAddr(accAddr), .accIsRefresh(accIsRefresh),
    .accEnd(accEnd), .busGntN(busGntN),
    .busReqN(zBusReqN), .accStart(zAccStart), .accDone(zAccDone)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mkAddr(input int region);
    return {region[2:0], 29'h0000_1234};
  endfunction

  task automatic cfgWrite(input logic share, input logic sdram);
    cfgWrEn = 1'b1; cfgShareEn = share; cfgSdram = sdram;
    tick();
    cfgWrEn = 1'b0;
  endtask

  task automatic privateAccess(input int region, input string tag);
    accReq = 1'b1; accAddr = mkAddr(region); accIsRefresh = 1'b0;
    tick();
    accReq = 1'b0;
    chk({tag, " start on accept"}, accStart, 1);
    chk({tag, " request stays high"}, busReqN, 1);
    tick();
    chk({tag, " start one cycle"}, accStart, 0);
    accEnd = 1'b1;
    tick();
    accEnd = 1'b0;
    chk({tag, " R7 done on end edge"}, accDone, 1);
    tick();
    chk({tag, " R7 done one cycle"}, accDone, 0);
  endtask

  // drives a shared request up to the launch; leaves the access running
  task automatic sharedToRun(input string tag);
    accReq = 1'b1; accAddr = mkAddr(2); accIsRefresh = 1'b0;
    tick();
    accReq = 1'b0;
    chk({tag, " R2 request low on accept"}, busReqN, 0);
    tick(); tick();
    chk({tag, " R2 no start without grant"}, accStart, 0);
    busGntN = 1'b0;
    tick();
    busGntN = 1'b1;
    tick(); tick();
    chk({tag, " R3 single low grant discarded"}, accStart, 0);
    busGntN = 1'b0;
    tick();
    tick();
    chk({tag, " R4 no start at second sample"}, accStart, 0);
    tick();
    chk({tag, " R4 start two edges after"}, accStart, 1);
    chk({tag, " R4 request still low"}, busReqN, 0);
    tick();
    chk({tag, " R4 start one cycle"}, accStart, 0);
  endtask

  task automatic t_reset();
    chk("R10 request high after reset", busReqN, 1);
    chk("R10 start low after reset", accStart, 0);
    chk("R10 done low after reset", accDone, 0);
  endtask

  task automatic t_private_mode_off();
    privateAccess(2, "R1 R10 sharing off region2");
  endtask

  task automatic t_private_region();
    cfgWrite(1'b1, 1'b0);
    privateAccess(5, "R1 R9 region5");
    privateAccess(3, "R1 R9 region3");
  endtask

  task automatic t_shared_plain();
    sharedToRun("plain");
    accReq = 1'b1; accAddr = mkAddr(5);
    tick();
    accReq = 1'b0;
    chk("R7 request during access ignored", accStart, 0);
    tick();
    chk("R5 request held until end", busReqN, 0);
    accEnd = 1'b1;
    tick();
    accEnd = 1'b0;
    chk("R5 request released on end edge", busReqN, 1);
    chk("R7 done not yet", accDone, 0);
    tick();
    chk("R7 done after release", accDone, 1);
    tick();
    chk("R7 done one cycle", accDone, 0);
    busGntN = 1'b1;
  endtask

  task automatic t_refresh_drop();
    accReq = 1'b1; accAddr = mkAddr(2); accIsRefresh = 1'b1;
    tick();
    accReq = 1'b0; accIsRefresh = 1'b0;
    chk("R8 refresh no request", busReqN, 1);
    chk("R8 refresh no start", accStart, 0);
    chk("R8 refresh done next edge", accDone, 1);
    tick();
    chk("R8 refresh done one cycle", accDone, 0);
  endtask

  task automatic t_sdram_wait();
    cfgWrite(1'b1, 1'b1);
    sharedToRun("sdram");
    accEnd = 1'b1;
    tick();
    accEnd = 1'b0;
    chk("R6 zero wait releases on end", zBusReqN, 1);
    for (int i = 0; i < 3; i++) begin
      chk("R6 request held in precharge", busReqN, 0);
      tick();
    end
    chk("R6 request released after wait", busReqN, 1);
    chk("R6 done not yet", accDone, 0);
    tick();
    chk("R6 R7 done after wait", accDone, 1);
    busGntN = 1'b1;
    tick();
  endtask

  task automatic t_soft_reset();
    cfgWrite(1'b1, 1'b0);
    accReq = 1'b1; accAddr = mkAddr(2);
    tick();
    accReq = 1'b0;
    chk("R11 request low before soft reset", busReqN, 0);
    softRstN = 1'b0;
    tick();
    chk("R11 soft reset releases request", busReqN, 1);
    softRstN = 1'b1;
    tick();
    accReq = 1'b1; accAddr = mkAddr(2);
    tick();
    accReq = 1'b0;
    chk("R11 sharing kept across soft reset", busReqN, 0);
    softRstN = 1'b0;
    tick();
    softRstN = 1'b1;
    tick();
  endtask

  task automatic t_por_clear();
    porRstN = 1'b0;
    tick();
    porRstN = 1'b1;
    tick();
    privateAccess(2, "R10 power-on clears sharing");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    porRstN = 1'b1;
    softRstN = 1'b1;
    tick();
    t_reset();
    t_private_mode_off();
    t_private_region();
    t_shared_plain();
    t_refresh_drop();
    t_sdram_wait();
    t_soft_reset();
    t_por_clear();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule